// File: doc/BRIEF.md
# Token-Chained Deep FIFO

This block builds one deep first-in/first-out buffer from several identical shallow slices joined in a ring. Every slice sees the same write strobe, read strobe and write data. Two tokens travel around the ring. The slice that holds the write token is the only one that stores an incoming word. The slice that holds the read token is the only one that puts its head word onto the shared output. When a slice fills its last physical location, it passes the write token forward with a one-cycle pulse. When it drains its last physical location, it passes the read token forward in the same way. The last slice hands its tokens back to the first.

A per-slice first-load input picks the starting slice. At reset, the slice whose first-load input is low takes both tokens. Each slice has its own active-low empty and full flags. The block merges these into one empty flag and one full flag for the whole chain. A user sees a single buffer with a depth of slice depth times slice count. Reads are registered: the word leaves on the edge that accepts the read.

Top module: `fifo_chain`

## Requirements
- R1: On the first cycle after a synchronous reset, `empty_n` is 0, `full_n` is 1 and `rd_data` is 0. Slice index `FIRST_SLICE` (default 0) holds both tokens.
- R2: Words leave in the order they entered, across any mix of writes and reads.
- R3: `full_n` is 0 exactly when the chain holds `NUM_SLICES*SLICE_DEPTH` words. A write strobe while `full_n` is 0 stores nothing.
- R4: `empty_n` is 0 exactly when the chain holds no word. A read strobe while `empty_n` is 0 removes nothing and leaves `rd_data` unchanged.
- R5: A write to a slice's last location passes the write token to the next slice on that same edge, so the next write lands in the next slice with no idle cycle. The last slice wraps to the first. Exactly one slice holds the write token at any time.
- R6: A read of a slice's last location passes the read token to the next slice on that same edge, with the same wrap. Exactly one slice holds the read token at any time.
- R7: When `wr_en` and `rd_en` are both 1 and the chain is neither empty nor full, both the write and the read take place, and the word count does not change.
- R8: An accepted read puts its word on `rd_data` in the cycle after the strobe edge. `rd_data` then keeps that word until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WIDTH | Last word read (registered) |
| empty_n | output | 1 | Merged empty flag, low when the chain is empty |
| full_n | output | 1 | Merged full flag, low when the chain is full |

## Verification
The bench runs long back-to-back write bursts and read bursts so that each token crosses every slice boundary, including the wrap from the last slice to the first. A design that left a gap at a hand-off, or sent a word to the wrong slice, would then return words out of order. The bench also writes into a full chain and reads from an empty one, and checks the flags and data afterwards. A design that overflowed would overwrite the oldest word. A design that underflowed would change `rd_data` or spoil the count. Finally, the bench drives simultaneous reads and writes while the pointers wrap. A merge of the flags built with the wrong logic would report empty or full with words still inside the chain.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

    // Token hand-off pulses between neighbouring slices
    typedef struct packed {
        logic wr;
        logic rd;
    } xtok_t;

    // Per-slice status, both active low
    typedef struct packed {
        logic empty_n;
        logic full_n;
    } sflag_t;

    function automatic int unsigned last_index(input int unsigned depth);
        return depth - 1;
    endfunction

    function automatic int unsigned ptr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/slice_store.sv
module slice_store #(
    parameter int unsigned WIDTH = 9,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PW   = fifo_chain_pkg::ptr_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/chain_slice.sv
module chain_slice
    import fifo_chain_pkg::*;
#(
    parameter int unsigned WIDTH = 9,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             first_load_n,
    input  xtok_t            xin,
    output xtok_t            xout,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_word,
    output sflag_t           flags,
    output logic             wtok_o,
    output logic             rtok_o
);
    localparam int unsigned PW = ptr_bits(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(last_index(DEPTH));
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [PW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;
    logic             wtok, rtok;
    logic             wr_fire, rd_fire;
    logic [WIDTH-1:0] head;

    assign wr_fire = wr_en && wtok && (count != FULLC);
    assign rd_fire = rd_en && rtok && (count != '0);

    // combinational hand-off so the neighbour takes the token on this edge
    assign xout.wr = wr_fire && (wptr == LAST);
    assign xout.rd = rd_fire && (rptr == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            wtok  <= !first_load_n;
            rtok  <= !first_load_n;
        end else begin
            if (wr_fire) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (rd_fire) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({wr_fire, rd_fire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            wtok <= (wtok && !xout.wr) || xin.wr;
            rtok <= (rtok && !xout.rd) || xin.rd;
        end
    end

    slice_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk  (clk),
        .we   (wr_fire),
        .waddr(wptr),
        .wdata(wr_data),
        .raddr(rptr),
        .rdata(head)
    );

    assign rd_word       = rtok ? head : '0;
    assign flags.empty_n = (count != '0);
    assign flags.full_n  = (count != FULLC);
    assign wtok_o        = wtok;
    assign rtok_o        = rtok;
endmodule

// File: rtl/chain_merge.sv
module chain_merge
    import fifo_chain_pkg::*;
#(
    parameter int unsigned N     = 3,
    parameter int unsigned WIDTH = 9
) (
    input  sflag_t           sflags [N],
    input  logic [WIDTH-1:0] words  [N],
    output logic             empty_n,
    output logic             full_n,
    output logic [WIDTH-1:0] word
);
    // OR of active-low flags: low only when every slice reports it
    always_comb begin
        empty_n = 1'b0;
        full_n  = 1'b0;
        word    = '0;
        for (int i = 0; i < int'(N); i++) begin
            empty_n = empty_n | sflags[i].empty_n;
            full_n  = full_n  | sflags[i].full_n;
            word    = word    | words[i];
        end
    end
endmodule

// File: rtl/fifo_chain.sv
module fifo_chain
    import fifo_chain_pkg::*;
#(
    parameter int unsigned WIDTH       = 9,
    parameter int unsigned SLICE_DEPTH = 8,
    parameter int unsigned NUM_SLICES  = 3,
    parameter int unsigned FIRST_SLICE = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty_n,
    output logic             full_n
);
    xtok_t            xo     [NUM_SLICES];
    sflag_t           sflags [NUM_SLICES];
    logic [WIDTH-1:0] words  [NUM_SLICES];
    logic [NUM_SLICES-1:0] wtok_vec, rtok_vec;
    logic [WIDTH-1:0] head_word;

    for (genvar g = 0; g < int'(NUM_SLICES); g++) begin : g_slice
        localparam int unsigned PREV = (g + NUM_SLICES - 1) % NUM_SLICES;
        chain_slice #(.WIDTH(WIDTH), .DEPTH(SLICE_DEPTH)) u_slice (
            .clk         (clk),
            .rst         (rst),
            .first_load_n(g != int'(FIRST_SLICE)),
            .xin         (xo[PREV]),
            .xout        (xo[g]),
            .wr_en       (wr_en),
            .wr_data     (wr_data),
            .rd_en       (rd_en),
            .rd_word     (words[g]),
            .flags       (sflags[g]),
            .wtok_o      (wtok_vec[g]),
            .rtok_o      (rtok_vec[g])
        );
    end

    chain_merge #(.N(NUM_SLICES), .WIDTH(WIDTH)) u_merge (
        .sflags (sflags),
        .words  (words),
        .empty_n(empty_n),
        .full_n (full_n),
        .word   (head_word)
    );

    always_ff @(posedge clk) begin
        if (rst)                   rd_data <= '0;
        else if (rd_en && empty_n) rd_data <= head_word;
    end
endmodule

// File: rtl/fifo_chain_chk.sv
module fifo_chain_chk #(
    parameter int unsigned N     = 3,
    parameter int unsigned WIDTH = 9,
    parameter int unsigned FIRST = 0
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic             empty_n,
    input logic             full_n,
    input logic [WIDTH-1:0] rd_data,
    input logic [N-1:0]     wtok_vec,
    input logic [N-1:0]     rtok_vec
);
    function automatic logic [N-1:0] rot(input logic [N-1:0] v);
        logic [N-1:0] r;
        for (int i = 0; i < int'(N); i++) r[(i + 1) % N] = v[i];
        return r;
    endfunction

    localparam logic [N-1:0] START = N'(1) << FIRST;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!empty_n && full_n && rd_data == '0));
    a_r1_first_tokens: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wtok_vec == START && rtok_vec == START));
    a_r5_wtok_single: assert property (@(posedge clk) disable iff (rst)
        $onehot(wtok_vec));
    a_r6_rtok_single: assert property (@(posedge clk) disable iff (rst)
        $onehot(rtok_vec));
    a_r5_wtok_forward: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && wtok_vec != $past(wtok_vec)) |-> wtok_vec == rot($past(wtok_vec)));
    a_r6_rtok_forward: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rtok_vec != $past(rtok_vec)) |-> rtok_vec == rot($past(rtok_vec)));
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && !full_n) |=> !full_n);
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !empty_n) |=> $stable(rd_data));
    a_r8_data_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        empty_n || full_n);
endmodule

bind fifo_chain fifo_chain_chk #(
    .N(NUM_SLICES), .WIDTH(WIDTH), .FIRST(FIRST_SLICE)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .empty_n (empty_n),
    .full_n  (full_n),
    .rd_data (rd_data),
    .wtok_vec(wtok_vec),
    .rtok_vec(rtok_vec)
);

// File: tb/tb_fifo_chain.sv
`timescale 1ns/1ps
module tb_fifo_chain;
    localparam int W   = 9;
    localparam int D   = 8;
    localparam int N   = 3;
    localparam int CAP = N * D;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic [W-1:0] rd_data;
    logic         empty_n, full_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 0;
    string tag = "R2";

    int           q[$];
    logic [W-1:0] exp_rd = '0;

    always #2 clk = ~clk;

    fifo_chain #(.WIDTH(W), .SLICE_DEPTH(D), .NUM_SLICES(N)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .empty_n(empty_n), .full_n(full_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        end
        $finish;
    endtask

    task automatic compare_all();
        check("R4", "empty_n", int'(empty_n), (q.size() != 0) ? 1 : 0);
        check("R3", "full_n",  int'(full_n),  (q.size() != CAP) ? 1 : 0);
        check(tag,  "rd_data", int'(rd_data), int'(exp_rd));
    endtask

    // one cycle: drive at negedge, update model at edge, compare after it
    task automatic cyc(input logic w, input logic [W-1:0] d, input logic r);
        bit wacc, racc;
        wr_en = w; wr_data = d; rd_en = r;
        @(posedge clk);
        wacc = w && (q.size() < CAP);
        racc = r && (q.size() > 0);
        if (racc) exp_rd = W'(q.pop_front());
        if (wacc) q.push_back(int'(d));
        #1;
        compare_all();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        #(4 * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        // R1: state right after reset
        check("R1", "empty_n after reset", int'(empty_n), 0);
        check("R1", "full_n after reset",  int'(full_n),  1);
        check("R1", "rd_data after reset", int'(rd_data), 0);
        @(negedge clk);

        // R4: reads on empty leave everything alone
        tag = "R4";
        for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b1);

        // R5: back-to-back fill across every slice boundary
        tag = "R5";
        for (int i = 0; i < CAP; i++) cyc(1'b1, W'(i + 17), 1'b0);
        check("R3", "full_n after fill", int'(full_n), 0);

        // R3: writes while full must not store
        tag = "R3";
        for (int i = 0; i < 4; i++) cyc(1'b1, W'(500 + i), 1'b0);

        // R6: back-to-back drain crossing each boundary and the wrap
        tag = "R6";
        for (int i = 0; i < CAP; i++) cyc(1'b0, '0, 1'b1);
        check("R4", "empty_n after drain", int'(empty_n), 0);

        // R8: data held through idle and empty reads
        tag = "R8";
        for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b0);
        cyc(1'b1, W'(123), 1'b0);
        cyc(1'b0, '0, 1'b1);
        for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b0);

        // R7: concurrent traffic at mid level over several laps
        tag = "R7";
        for (int i = 0; i < CAP / 2; i++) cyc(1'b1, W'(200 + i), 1'b0);
        for (int i = 0; i < 3 * CAP; i++) cyc(1'b1, W'(i * 7 + 3), 1'b1);

        // R7 boundary: simultaneous strobes on full and on empty
        for (int i = 0; i < CAP; i++) cyc(1'b1, W'(i + 300), 1'b0);
        cyc(1'b1, W'(77), 1'b1);
        cyc(1'b1, W'(78), 1'b1);
        while (q.size() > 0) cyc(1'b0, '0, 1'b1);
        cyc(1'b1, W'(91), 1'b1);
        cyc(1'b0, '0, 1'b1);

        // R2: random mix of strobes
        tag = "R2";
        for (int i = 0; i < 3000; i++)
            cyc(1'($urandom_range(0, 1)), W'($urandom_range(0, 511)), 1'($urandom_range(0, 1)));
        while (q.size() > 0) cyc(1'b0, '0, 1'b1);

        report();
    end
endmodule